// File: doc/BRIEF.md
# Per-Rank ODT Mask Driver

This block drives the four on-die-termination pins of a DRAM controller, one pin per rank. Whenever the command scheduler issues a read or a write to a rank, the block looks up a termination pattern in one of two programmable masks and drives it onto the pins for a programmable window. One mask covers writes and the other covers reads. Each mask has one field per target rank. The scheduler is seen only as a command strobe, a rank number and a direction bit.

A simple host write port loads three configuration words: the write mask, the read mask, and a timing word that sets the lead delay and the hold length. A read never terminates the rank being read, whatever its mask field holds. The configuration cannot change under an active window. A host write that lands during a window is parked and takes effect once the pins are quiet.

Top module: `odt_mask_driver`

## Requirements
- R1: Synchronous active-high reset drives all four ODT pins low, clears both masks and sets the timing word to delay 0, hold 1. With cleared masks, commands leave the pins low.
- R2: For a write command to rank r, the window pattern is bits [8r+3:8r] of the write-mask word (address 0). Bit k of the pattern drives the pin of rank k, and bits [8r+7:8r+4] are ignored.
- R3: For a read command to rank r, the window pattern is bits [4r+3:4r] of the read-mask word (address 1). Bits [31:16] of that word have no effect.
- R4: During a read window, the pin of the rank being read is low regardless of its read-mask bit.
- R5: With delay D in timing-word bits [3:0] (address 2), the pins stay low for the D cycles that follow the clock edge that accepts the command. The pattern appears after edge T+D, where T is the accepting edge.
- R6: With hold H in timing-word bits [7:4], the pattern is held for H cycles and then the pins return low. H = 0 is treated as 1.
- R7: A command accepted while a window is pending or active abandons that window. It starts a fresh delay and hold using the new command's rank, direction and pattern.
- R8: Outside a window all ODT pins are low. Within one, the pins show only the latched pattern.
- R9: A configuration write accepted at an edge where no window is active takes effect at that edge. A command accepted at the same edge still uses the previous values.
- R10: A configuration write accepted while a window is pending or active is held and applied at the first edge that sees no window. A later write to the same word overwrites the held value, and nothing changes while the window runs.
- R11: Writes to address 3 have no effect on any mask or on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_addr | input | 2 | 0 write mask, 1 read mask, 2 timing, 3 unused |
| cfg_wdata | input | 32 | Host write data |
| cmd_valid | input | 1 | Command accepted this cycle |
| cmd_rank | input | 2 | Target rank of the command |
| cmd_read | input | 1 | 1 = read, 0 = write |
| odt | output | 4 | ODT pins, bit k for rank k |

## Verification
The bench uses the package defaults: four ranks, 8-bit write fields, 4-bit read fields and 4-bit delay and hold fields. This makes every rank and both directions reachable, along with the full delay range 0 to 15 and the hold range including the zero-means-one case. With these defaults a window is at most 30 cycles long, so back-to-back restarts are cheap to exercise. So are parked host writes that land in the lead phase, in the hold phase and on the exact edge where a window closes. A long pseudo-random stretch then mixes commands and host writes against the behavioural model.

// File: rtl/odt_mask_pkg.sv
`timescale 1ns/1ps
package odt_mask_pkg;

    localparam int NUM_RANKS  = 4;
    localparam int RANK_W     = $clog2(NUM_RANKS);
    localparam int WR_FIELD_W = 8;
    localparam int RD_FIELD_W = 4;
    localparam int CFG_DW     = 32;
    localparam int CFG_AW     = 2;
    localparam int TIM_W      = 4;
    localparam int WR_USED    = NUM_RANKS * WR_FIELD_W;
    localparam int RD_USED    = NUM_RANKS * RD_FIELD_W;

    typedef logic [NUM_RANKS-1:0] odt_vec_t;

    typedef enum logic [CFG_AW-1:0] {
        CFG_WMASK  = 2'd0,
        CFG_RMASK  = 2'd1,
        CFG_TIMING = 2'd2,
        CFG_SPARE  = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic [TIM_W-1:0] hold;
        logic [TIM_W-1:0] lead;
    } timing_t;

    typedef struct packed {
        logic [CFG_DW-1:0] wmask;
        logic [CFG_DW-1:0] rmask;
        timing_t           tim;
    } odt_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    localparam timing_t TIMING_RST = '{hold: TIM_W'(1), lead: '0};
    localparam odt_cfg_t CFG_RST = '{wmask: '0, rmask: '0, tim: TIMING_RST};

    function automatic logic [TIM_W-1:0] hold_len(input logic [TIM_W-1:0] raw);
        return (raw == '0) ? TIM_W'(1) : raw;
    endfunction

endpackage

// File: rtl/odt_cfg_bank.sv
`timescale 1ns/1ps
module odt_cfg_bank
    import odt_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              busy,
    output odt_cfg_t          cfg,
    output logic [2:0]        pend
);

    odt_cfg_t   live_q;
    odt_cfg_t   park_q;
    logic [2:0] park_vld_q;
    cfg_addr_e  sel;

    assign sel = cfg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q     <= CFG_RST;
            park_q     <= CFG_RST;
            park_vld_q <= '0;
        end else if (!busy) begin
            if (park_vld_q[0]) live_q.wmask <= park_q.wmask;
            if (park_vld_q[1]) live_q.rmask <= park_q.rmask;
            if (park_vld_q[2]) live_q.tim   <= park_q.tim;
            park_vld_q <= '0;
            if (we) begin
                case (sel)
                    CFG_WMASK:  live_q.wmask <= wdata;
                    CFG_RMASK:  live_q.rmask <= wdata;
                    CFG_TIMING: live_q.tim   <= timing_t'(wdata[2*TIM_W-1:0]);
                    default: ;
                endcase
            end
        end else if (we) begin
            case (sel)
                CFG_WMASK: begin
                    park_q.wmask  <= wdata;
                    park_vld_q[0] <= 1'b1;
                end
                CFG_RMASK: begin
                    park_q.rmask  <= wdata;
                    park_vld_q[1] <= 1'b1;
                end
                CFG_TIMING: begin
                    park_q.tim    <= timing_t'(wdata[2*TIM_W-1:0]);
                    park_vld_q[2] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign cfg  = live_q;
    assign pend = park_vld_q;

endmodule

// File: rtl/odt_pattern_sel.sv
`timescale 1ns/1ps
module odt_pattern_sel
    import odt_mask_pkg::*;
(
    input  logic [CFG_DW-1:0] wmask,
    input  logic [CFG_DW-1:0] rmask,
    input  logic [RANK_W-1:0] rank,
    input  logic              is_read,
    output odt_vec_t          pat
);

    odt_vec_t             wr_cand [NUM_RANKS];
    odt_vec_t             rd_cand [NUM_RANKS];
    logic [NUM_RANKS-1:0] unused_wr_hi;
    logic                 unused_rd_hi;

    // One candidate per target rank; the read copy never terminates its own rank.
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        assign wr_cand[r] = wmask[r*WR_FIELD_W +: NUM_RANKS];
        assign rd_cand[r] = rmask[r*RD_FIELD_W +: NUM_RANKS] & ~(odt_vec_t'(1) << r);
        if (WR_FIELD_W > NUM_RANKS) begin : g_wr_spare
            assign unused_wr_hi[r] = ^wmask[r*WR_FIELD_W+NUM_RANKS +: WR_FIELD_W-NUM_RANKS];
        end else begin : g_wr_full
            assign unused_wr_hi[r] = 1'b0;
        end
    end

    if (RD_USED < CFG_DW) begin : g_rd_spare
        assign unused_rd_hi = ^rmask[CFG_DW-1:RD_USED];
    end else begin : g_rd_full
        assign unused_rd_hi = 1'b0;
    end

    assign pat = is_read ? rd_cand[rank] : wr_cand[rank];

endmodule

// File: rtl/odt_window_timer.sv
`timescale 1ns/1ps
module odt_window_timer
    import odt_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic              cmd_read,
    input  odt_vec_t          pat,
    input  timing_t           tim,
    output odt_vec_t          odt,
    output logic              busy,
    output logic [RANK_W-1:0] cur_rank,
    output logic              cur_read,
    output odt_vec_t          cur_pat
);

    phase_e            phase_q;
    logic [TIM_W-1:0]  cnt_q;
    logic [TIM_W-1:0]  hold_q;
    odt_vec_t          pat_q;
    odt_vec_t          odt_q;
    logic [RANK_W-1:0] rank_q;
    logic              read_q;
    logic [TIM_W-1:0]  new_hold;

    assign new_hold = hold_len(tim.hold);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            hold_q  <= TIM_W'(1);
            pat_q   <= '0;
            odt_q   <= '0;
            rank_q  <= '0;
            read_q  <= 1'b0;
        end else if (cmd_valid) begin
            pat_q  <= pat;
            rank_q <= cmd_rank;
            read_q <= cmd_read;
            hold_q <= new_hold;
            if (tim.lead == '0) begin
                phase_q <= PH_HOLD;
                cnt_q   <= new_hold - TIM_W'(1);
                odt_q   <= pat;
            end else begin
                phase_q <= PH_LEAD;
                cnt_q   <= tim.lead - TIM_W'(1);
                odt_q   <= '0;
            end
        end else begin
            case (phase_q)
                PH_LEAD: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= hold_q - TIM_W'(1);
                        odt_q   <= pat_q;
                    end else begin
                        cnt_q <= cnt_q - TIM_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        odt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - TIM_W'(1);
                    end
                end
                default: odt_q <= '0;
            endcase
        end
    end

    assign odt      = odt_q;
    assign busy     = (phase_q != PH_IDLE);
    assign cur_rank = rank_q;
    assign cur_read = read_q;
    assign cur_pat  = pat_q;

endmodule

// File: rtl/odt_mask_driver.sv
`timescale 1ns/1ps
module odt_mask_driver
    import odt_mask_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    input  logic                 cmd_valid,
    input  logic [RANK_W-1:0]    cmd_rank,
    input  logic                 cmd_read,
    output logic [NUM_RANKS-1:0] odt
);

    odt_cfg_t          cfg_live;
    logic [2:0]        cfg_pend;
    logic              win_busy;
    logic [RANK_W-1:0] win_rank;
    logic              win_read;
    odt_vec_t          win_pat;
    odt_vec_t          sel_pat;
    odt_vec_t          odt_drv;

    odt_cfg_bank u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .busy  (win_busy),
        .cfg   (cfg_live),
        .pend  (cfg_pend)
    );

    odt_pattern_sel u_sel (
        .wmask   (cfg_live.wmask),
        .rmask   (cfg_live.rmask),
        .rank    (cmd_rank),
        .is_read (cmd_read),
        .pat     (sel_pat)
    );

    odt_window_timer u_tmr (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_rank  (cmd_rank),
        .cmd_read  (cmd_read),
        .pat       (sel_pat),
        .tim       (cfg_live.tim),
        .odt       (odt_drv),
        .busy      (win_busy),
        .cur_rank  (win_rank),
        .cur_read  (win_read),
        .cur_pat   (win_pat)
    );

    assign odt = odt_drv;

endmodule

// File: rtl/odt_mask_driver_chk.sv
`timescale 1ns/1ps
module odt_mask_driver_chk
    import odt_mask_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input odt_vec_t          odt,
    input logic              busy,
    input logic [RANK_W-1:0] cur_rank,
    input logic              cur_read,
    input odt_vec_t          cur_pat,
    input logic              cmd_valid,
    input odt_cfg_t          cfg,
    input logic [2:0]        pend
);

    p_read_target_low_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_read) |-> !odt[cur_rank]);

    p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (odt == '0));

    p_only_latched_bits_r8: assert property (@(posedge clk) disable iff (rst)
        (odt & ~cur_pat) == '0);

    p_cmd_opens_window_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> busy);

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    p_park_drained_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (pend == '0));

endmodule

bind odt_mask_driver odt_mask_driver_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .odt       (odt),
    .busy      (win_busy),
    .cur_rank  (win_rank),
    .cur_read  (win_read),
    .cur_pat   (win_pat),
    .cmd_valid (cmd_valid),
    .cfg       (cfg_live),
    .pend      (cfg_pend)
);

// File: tb/odt_mask_driver_tb.sv
`timescale 1ns/1ps
module odt_mask_driver_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cmd_valid;
    logic [1:0]  cmd_rank;
    logic        cmd_read;
    logic [3:0]  odt;

    always #2 clk = ~clk;

    odt_mask_driver u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_rank(cmd_rank),
        .cmd_read(cmd_read), .odt(odt)
    );

    // behavioural reference: window as a pair of edge timestamps
    int          n, w_start, w_end;
    logic [3:0]  w_pat;
    logic [31:0] m_wmask, m_rmask, q_wmask, q_rmask;
    logic [7:0]  m_tim, q_tim;
    bit          pw, pr, pt;
    int          checks = 0;
    int          fails = 0;
    string       tag = "R1";
    bit          done = 0;

    function automatic logic [3:0] exp_pat(input logic [1:0] rk, input logic rd);
        logic [3:0] v;
        if (rd) begin
            v = 4'((m_rmask >> (4*rk)) & 32'hF);
            v[rk] = 1'b0;
        end else begin
            v = 4'((m_wmask >> (8*rk)) & 32'hF);
        end
        return v;
    endfunction

    task automatic model_reset();
        n = 0; w_start = 0; w_end = 0; w_pat = '0;
        m_wmask = '0; m_rmask = '0; m_tim = 8'h10;
        q_wmask = '0; q_rmask = '0; q_tim = '0;
        pw = 0; pr = 0; pt = 0;
    endtask

    task automatic model_edge();
        bit busy_before;
        int d, h;
        n++;
        busy_before = (n - 1) < w_end;
        if (cmd_valid) begin
            d = int'(m_tim[3:0]);
            h = int'(m_tim[7:4]);
            if (h == 0) h = 1;
            w_pat   = exp_pat(cmd_rank, cmd_read);
            w_start = n + d;
            w_end   = n + d + h;
        end
        if (!busy_before) begin
            if (pw) m_wmask = q_wmask;
            if (pr) m_rmask = q_rmask;
            if (pt) m_tim   = q_tim;
            pw = 0; pr = 0; pt = 0;
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: m_wmask = cfg_wdata;
                    2'd1: m_rmask = cfg_wdata;
                    2'd2: m_tim   = cfg_wdata[7:0];
                    default: ;
                endcase
            end
        end else if (cfg_we) begin
            case (cfg_addr)
                2'd0: begin q_wmask = cfg_wdata; pw = 1; end
                2'd1: begin q_rmask = cfg_wdata; pr = 1; end
                2'd2: begin q_tim = cfg_wdata[7:0]; pt = 1; end
                default: ;
            endcase
        end
    endtask

    task automatic check(input logic [3:0] exp);
        checks++;
        if (odt !== exp) begin
            fails++;
            $display("FAIL %s: odt=%h expected %h at cycle %0d", tag, odt, exp, n);
        end
    endtask

    task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d,
                        input logic cv, input logic [1:0] rk, input logic rd);
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        cmd_valid = cv; cmd_rank = rk; cmd_read = rd;
        @(posedge clk);
        model_edge();
        #1;
        check((n >= w_start && n < w_end) ? w_pat : 4'h0);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic cfgw(input logic [1:0] a, input logic [31:0] d);
        step(1, a, d, 0, 0, 0);
    endtask

    task automatic cmd(input logic [1:0] rk, input logic rd);
        step(0, 0, 0, 1, rk, rd);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst = 1'b1;
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        cmd_valid = 0; cmd_rank = 0; cmd_read = 0;
        // R1: pins low through reset
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1; check(4'h0);
        end
        rst = 1'b0;
        model_reset();
        tag = "R1";
        idle(2);
        cmd(2'd0, 1'b0); idle(2);
        cmd(2'd3, 1'b1); idle(3);

        // R9: idle writes apply directly; R2 write patterns
        tag = "R9";
        cfgw(2'd0, 32'h0c0c0303);
        cfgw(2'd2, 32'h0000_0032);
        tag = "R2";
        for (int r = 0; r < 4; r++) begin
            cmd(2'(r), 1'b0); idle(6);
        end
        cfgw(2'd0, 32'hA5C3_96F1);
        for (int r = 0; r < 4; r++) begin
            cmd(2'(r), 1'b0); idle(6);
        end

        // R3 read fields, upper half ignored; R4 target bit forced low
        tag = "R3";
        cfgw(2'd1, 32'hDEAD_F0FF);
        for (int r = 0; r < 4; r++) begin
            cmd(2'(r), 1'b1); idle(6);
        end
        tag = "R4";
        cfgw(2'd1, 32'hFFFF_FFFF);
        for (int r = 0; r < 4; r++) begin
            cmd(2'(r), 1'b1); idle(6);
        end

        // R5 lead delay
        tag = "R5";
        cfgw(2'd2, 32'h25); cmd(2'd0, 1'b0); idle(9);
        cfgw(2'd2, 32'h40); cmd(2'd2, 1'b0); idle(6);
        cfgw(2'd2, 32'h3F); cmd(2'd1, 1'b1); idle(20);

        // R6 hold length, zero means one
        tag = "R6";
        cfgw(2'd2, 32'h00); cmd(2'd0, 1'b0); idle(3);
        cfgw(2'd2, 32'hF0); cmd(2'd3, 1'b0); idle(18);
        cfgw(2'd2, 32'h01); cmd(2'd1, 1'b0); idle(4);

        // R7 restart in lead phase, in hold phase, and back to back
        tag = "R7";
        cfgw(2'd2, 32'h43);
        cmd(2'd0, 1'b0); idle(1);
        cmd(2'd3, 1'b1); idle(4);
        cmd(2'd2, 1'b0); idle(10);
        for (int i = 0; i < 5; i++) cmd(2'(i), i[0]);
        idle(10);

        // R10 parked writes, last one wins, applied after the window
        tag = "R10";
        cfgw(2'd2, 32'h52);
        cmd(2'd0, 1'b0);
        cfgw(2'd0, 32'h0102_0408);
        cfgw(2'd0, 32'h0F0F_0F0F);
        cfgw(2'd2, 32'h11);
        cfgw(2'd1, 32'h0000_00F0);
        idle(1);
        cmd(2'd1, 1'b0);
        idle(5);
        cmd(2'd1, 1'b0);
        idle(4);
        cmd(2'd1, 1'b1);
        idle(4);

        // R11 spare address ignored
        tag = "R11";
        cfgw(2'd3, 32'hFFFF_FFFF);
        cmd(2'd0, 1'b0); idle(4);
        cmd(2'd1, 1'b1); idle(4);
        cmd(2'd2, 1'b0); idle(4);

        // R8 mixed traffic against the model
        tag = "R8";
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[2:0] == 3'd5, lf[4:3], {lf, lf[7:0], lf[15:8]},
                 lf[7:5] == 3'd2, lf[9:8], lf[11]);
        end
        idle(35);

        done = 1;
        summary();
        $finish;
    end

endmodule